// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state of one to eight address-translation contexts. Each context exposes a control word, a translation-control word, a 40-bit table base split over two 32-bit words, an attribute word, a fault status word and a fault address word. All of these sit in a private 64-byte window. Software reaches them through a plain 32-bit register port. Writes take effect on the clock edge. Reads are combinational on the current address.

A translation engine, outside this block, reports faults as one-cycle pulses for each context. The shared payload carries the fault kind, an error code, an error level and the faulting address. The block keeps only the first fault until software clears the status word. Software clears it by writing any value to it, zero included. The block also raises one interrupt line for all contexts.

The block also runs a flush handshake with the engine. A flush written by software stays pending, and is visible both on a per-context output and in the control word, until the engine pulses the matching done input.

Top module: `xlat_ctx_regs`

## Requirements
- R1: After reset every register of every context reads 0, `irq` is 0 and `flush_req` is all zeros.
- R2: Register address = context index * 0x40 + offset. The offsets are: control 0x00, translation control 0x08, table base low 0x10, table base high 0x14, fault status 0x20, fault address 0x24, attribute 0x28. `rdata` reflects `addr` in the same cycle. A write changes only the addressed context.
- R3: The control word has these bits: translation enable at bit 0, flush at bit 1, interrupt enable at bit 2, TLB enable at bit 3, a 2-bit select field at bits 5:4, access-flag enable at bit 16 and an extra enable at bit 17. All other bits read 0. Writing 0 clears every field except a flush that is already pending.
- R4: Writing the control word with bit 1 set makes the flush pending. While it is pending, `flush_req[i]` is 1 and control bit 1 reads 1. A one-cycle pulse on `flush_done[i]` clears it in the next cycle. A flush written while one is pending merges into it, so one done pulse clears both. A done pulse with nothing pending has no effect. A flush write in the same cycle as a done pulse leaves the flush pending.
- R5: The table base is 40 bits. The low word is stored whole. Of the high word only bits 7:0 are stored, and its bits 31:8 read 0.
- R6: The translation-control and attribute words store and return all 32 bits.
- R7: A pulse on `flt_pulse[i]` with nonzero `flt_flags`, while context i has no fault flag set, captures the fault in the next cycle. The flag mapping is: `flt_flags` bit 0 to status bit 0 (translation fault), bit 1 to status bit 1 (page fault), bit 2 to status bit 2 (walk abort), bit 3 to status bit 4 (multiple hit). `flt_code` goes to status bits 10:8 and `flt_level` to bits 13:12. `flt_addr` goes to the fault address word.
- R8: While any fault flag of a context is set, further fault pulses for that context change neither its status nor its fault address.
- R9: Any write to the status word clears both the status word and the fault address word to 0, whatever value is written. This write wins over a fault pulse in the same cycle. Writes to the fault address word are ignored.
- R10: `irq` is the OR over all contexts of (interrupt enable AND any fault flag). It follows the registers with no further delay.
- R11: An access to a context index at or above `NUM_CTX`, or to any other offset, reads 0 and its writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| flt_pulse | input | NUM_CTX | Fault event, one bit per context |
| flt_flags | input | 4 | Fault kind flags of the event |
| flt_code | input | 3 | Error code of the event |
| flt_level | input | 2 | Error level of the event |
| flt_addr | input | 32 | Faulting address of the event |
| flush_done | input | NUM_CTX | Invalidation completed, one pulse per context |
| flush_req | output | NUM_CTX | Flush pending, one bit per context |
| irq | output | 1 | Combined fault interrupt |

## Verification
The bench builds the block with `NUM_CTX` = 3. The address space still decodes eight context windows, so indices 3 to 7 fall in the unused range. This makes the out-of-range read-zero and ignored-write behaviour visible at the port, next to three live contexts whose independence can be checked. Three contexts also let a fault in one context, a pending flush in another and an interrupt enable in a third coexist. The bench can then tell whether the interrupt OR and the flush outputs keep their contexts apart.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;

    localparam int MAX_CTX = 8;
    localparam int OFS_W   = 6;
    localparam int IDX_W   = $clog2(MAX_CTX);
    localparam int ADDR_W  = IDX_W + OFS_W;
    localparam int TB_W    = 40;
    localparam int TBHI_W  = TB_W - 32;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_TCTL  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_TBLO  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_TBHI  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h20;
    localparam logic [OFS_W-1:0] OFS_FADDR = 6'h24;
    localparam logic [OFS_W-1:0] OFS_ATTR  = 6'h28;

    typedef enum logic [2:0] {
        REG_NONE, REG_CTRL, REG_TCTL, REG_TBLO,
        REG_TBHI, REG_STAT, REG_FADDR, REG_ATTR
    } reg_sel_e;

    typedef struct packed {
        logic       ext_en;
        logic       af_en;
        logic [1:0] sel;
        logic       tlb_en;
        logic       irq_en;
        logic       xlat_en;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] level;
        logic [2:0] code;
        logic       mhit;
        logic       abort;
        logic       pf;
        logic       tf;
    } stat_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              flush_pend;
        logic [31:0]       tctl;
        logic [TB_W-1:0]   tbase;
        logic [31:0]       attr;
        stat_t             stat;
        logic [31:0]       faddr;
    } ctx_state_t;

    function automatic reg_sel_e offset_to_sel(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_CTRL:  return REG_CTRL;
            OFS_TCTL:  return REG_TCTL;
            OFS_TBLO:  return REG_TBLO;
            OFS_TBHI:  return REG_TBHI;
            OFS_STAT:  return REG_STAT;
            OFS_FADDR: return REG_FADDR;
            OFS_ATTR:  return REG_ATTR;
            default:   return REG_NONE;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_word(input ctrl_t c, input logic pend);
        return {14'b0, c.ext_en, c.af_en, 10'b0, c.sel, c.tlb_en, c.irq_en, pend, c.xlat_en};
    endfunction

    function automatic logic [31:0] stat_word(input stat_t s);
        return {18'b0, s.level, 1'b0, s.code, 3'b0, s.mhit, 1'b0, s.abort, s.pf, s.tf};
    endfunction

    function automatic logic any_fault(input stat_t s);
        return s.tf | s.pf | s.abort | s.mhit;
    endfunction

endpackage

// File: rtl/xlat_ctx_decode.sv
module xlat_ctx_decode
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = MAX_CTX
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output reg_sel_e          sel
);
    always_comb begin
        idx = addr[ADDR_W-1:OFS_W];
        if (int'(idx) < NUM_CTX)
            sel = offset_to_sel(addr[OFS_W-1:0]);
        else
            sel = REG_NONE;
    end
endmodule

// File: rtl/xlat_ctx_slice.sv
module xlat_ctx_slice
    import xlat_ctx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reg_sel_e    wr_sel,
    input  logic [31:0] wdata,
    input  logic        flt_pulse,
    input  logic [3:0]  flt_flags,
    input  logic [2:0]  flt_code,
    input  logic [1:0]  flt_level,
    input  logic [31:0] flt_addr,
    input  logic        flush_done,
    output ctx_state_t  st
);
    logic capture;

    assign capture = flt_pulse && (|flt_flags) && !any_fault(st.stat) && (wr_sel != REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (wr_sel)
                REG_CTRL: begin
                    st.ctrl.xlat_en <= wdata[0];
                    st.ctrl.irq_en  <= wdata[2];
                    st.ctrl.tlb_en  <= wdata[3];
                    st.ctrl.sel     <= wdata[5:4];
                    st.ctrl.af_en   <= wdata[16];
                    st.ctrl.ext_en  <= wdata[17];
                end
                REG_TCTL: st.tctl <= wdata;
                REG_TBLO: st.tbase[31:0] <= wdata;
                REG_TBHI: st.tbase[TB_W-1:32] <= wdata[TBHI_W-1:0];
                REG_ATTR: st.attr <= wdata;
                default: ;
            endcase

            // new flush request outranks a completion in the same cycle
            if (wr_sel == REG_CTRL && wdata[1])
                st.flush_pend <= 1'b1;
            else if (flush_done)
                st.flush_pend <= 1'b0;

            if (wr_sel == REG_STAT) begin
                st.stat  <= '0;
                st.faddr <= '0;
            end else if (capture) begin
                st.stat.tf    <= flt_flags[0];
                st.stat.pf    <= flt_flags[1];
                st.stat.abort <= flt_flags[2];
                st.stat.mhit  <= flt_flags[3];
                st.stat.code  <= flt_code;
                st.stat.level <= flt_level;
                st.faddr      <= flt_addr;
            end
        end
    end
endmodule

// File: rtl/xlat_ctx_regs.sv
module xlat_ctx_regs
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = MAX_CTX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_CTX-1:0] flt_pulse,
    input  logic [3:0]         flt_flags,
    input  logic [2:0]         flt_code,
    input  logic [1:0]         flt_level,
    input  logic [31:0]        flt_addr,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic [NUM_CTX-1:0] flush_req,
    output logic               irq
);
    logic [IDX_W-1:0] acc_idx;
    reg_sel_e         acc_sel;
    ctx_state_t       ctx_st [NUM_CTX];
    logic [NUM_CTX-1:0] ctx_irq;

    xlat_ctx_decode #(.NUM_CTX(NUM_CTX)) u_dec (
        .addr (addr),
        .idx  (acc_idx),
        .sel  (acc_sel)
    );

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        reg_sel_e ctx_wr;
        assign ctx_wr = (wr_en && acc_idx == IDX_W'(i)) ? acc_sel : REG_NONE;

        xlat_ctx_slice u_slice (
            .clk        (clk),
            .rst        (rst),
            .wr_sel     (ctx_wr),
            .wdata      (wdata),
            .flt_pulse  (flt_pulse[i]),
            .flt_flags  (flt_flags),
            .flt_code   (flt_code),
            .flt_level  (flt_level),
            .flt_addr   (flt_addr),
            .flush_done (flush_done[i]),
            .st         (ctx_st[i])
        );

        assign flush_req[i] = ctx_st[i].flush_pend;
        assign ctx_irq[i]   = ctx_st[i].ctrl.irq_en & any_fault(ctx_st[i].stat);
    end

    assign irq = |ctx_irq;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (acc_idx == IDX_W'(i)) begin
                case (acc_sel)
                    REG_CTRL:  rdata = ctrl_word(ctx_st[i].ctrl, ctx_st[i].flush_pend);
                    REG_TCTL:  rdata = ctx_st[i].tctl;
                    REG_TBLO:  rdata = ctx_st[i].tbase[31:0];
                    REG_TBHI:  rdata = {{(32-TBHI_W){1'b0}}, ctx_st[i].tbase[TB_W-1:32]};
                    REG_STAT:  rdata = stat_word(ctx_st[i].stat);
                    REG_FADDR: rdata = ctx_st[i].faddr;
                    REG_ATTR:  rdata = ctx_st[i].attr;
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/xlat_ctx_chk.sv
module xlat_ctx_chk
    import xlat_ctx_pkg::*;
#(
    parameter int NUM_CTX = MAX_CTX
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [31:0]        rdata,
    input logic [NUM_CTX-1:0] flt_pulse,
    input logic [NUM_CTX-1:0] flush_done,
    input logic [NUM_CTX-1:0] flush_req,
    input logic               irq
);
    // R4
    flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((flush_req & ~flush_done) != '0) |=>
            ((flush_req & $past(flush_req & ~flush_done)) == $past(flush_req & ~flush_done)));

    // R4
    flush_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((flush_req & ~$past(flush_req)) != '0) |-> $past(wr_en));

    // R11
    oob_read_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(addr[ADDR_W-1:OFS_W]) >= NUM_CTX) |-> (rdata == '0));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|flt_pulse) || wr_en));
endmodule

bind xlat_ctx_regs xlat_ctx_chk #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .flt_pulse  (flt_pulse),
    .flush_done (flush_done),
    .flush_req  (flush_req),
    .irq        (irq)
);

// File: tb/test_xlat_ctx_regs.sv
module test_xlat_ctx_regs;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NC-1:0] flt_pulse = '0;
    logic [3:0]    flt_flags = '0;
    logic [2:0]    flt_code = '0;
    logic [1:0]    flt_level = '0;
    logic [31:0]   flt_addr = '0;
    logic [NC-1:0] flush_done = '0;
    logic [NC-1:0] flush_req;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xlat_ctx_regs #(.NUM_CTX(NC)) i_xlat_ctx_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .flt_pulse(flt_pulse), .flt_flags(flt_flags), .flt_code(flt_code),
        .flt_level(flt_level), .flt_addr(flt_addr), .flush_done(flush_done),
        .flush_req(flush_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] ra(input int ctx, input logic [5:0] ofs);
        return 9'(ctx * 64) + {3'b0, ofs};
    endfunction

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic fault(input int ctx, input logic [3:0] f, input logic [2:0] c,
                         input logic [1:0] l, input logic [31:0] a);
        @(negedge clk);
        flt_pulse[ctx] = 1'b1; flt_flags = f; flt_code = c; flt_level = l; flt_addr = a;
        @(negedge clk);
        flt_pulse = '0;
    endtask

    task automatic done(input int ctx);
        @(negedge clk);
        flush_done[ctx] = 1'b1;
        @(negedge clk);
        flush_done = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int c = 0; c < NC; c++) begin
            rd(ra(c, 6'h00), v); check("R1 ctrl", v, 0);
            rd(ra(c, 6'h20), v); check("R1 stat", v, 0);
            rd(ra(c, 6'h10), v); check("R1 tbase", v, 0);
        end
        check("R1 irq", 32'(irq), 0);
        check("R1 flush_req", 32'(flush_req), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(ra(1, 6'h08), 32'hA5A5_1234);
        rd(ra(1, 6'h08), v); check("R6 tctl", v, 32'hA5A5_1234);
        rd(ra(0, 6'h08), v); check("R2 other ctx untouched", v, 0);
        wr(ra(2, 6'h28), 32'h0044_FF04);
        rd(ra(2, 6'h28), v); check("R6 attr", v, 32'h0044_FF04);
        wr(ra(0, 6'h10), 32'hDEAD_BEEF);
        wr(ra(0, 6'h14), 32'hFFFF_FF12);
        rd(ra(0, 6'h10), v); check("R5 tbase low", v, 32'hDEAD_BEEF);
        rd(ra(0, 6'h14), v); check("R5 tbase high", v, 32'h0000_0012);
        wr(ra(1, 6'h00), 32'hFFFF_FFFF);
        rd(ra(1, 6'h00), v); check("R3 ctrl layout", v, 32'h0003_003F);
        check("R4 flush_req from ctrl write", 32'(flush_req), 32'b010);
        done(1);
        wr(ra(1, 6'h00), 32'h0);
        rd(ra(1, 6'h00), v); check("R3 write zero disables", v, 0);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr(ra(0, 6'h00), 32'h2);
        rd(ra(0, 6'h00), v); check("R4 flush reads 1", v, 32'h2);
        wr(ra(0, 6'h00), 32'h3);
        repeat (3) @(negedge clk);
        rd(ra(0, 6'h00), v); check("R4 merged flush still pending", v, 32'h3);
        check("R4 flush_req held", 32'(flush_req), 32'b001);
        done(0);
        rd(ra(0, 6'h00), v); check("R4 done clears flush", v, 32'h1);
        check("R4 flush_req cleared", 32'(flush_req), 0);
        done(0);
        rd(ra(0, 6'h00), v); check("R4 idle done no effect", v, 32'h1);
        @(negedge clk);
        wr_en = 1'b1; addr = ra(0, 6'h00); wdata = 32'h3; flush_done[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flush_done = '0;
        check("R4 write beats same-cycle done", 32'(flush_req), 32'b001);
        done(0);
        check("R4 cleared after later done", 32'(flush_req), 0);
    endtask

    task automatic t_fault();
        logic [31:0] v;
        wr(ra(2, 6'h00), 32'h4);
        fault(2, 4'b0010, 3'd4, 2'd2, 32'h1234_5000);
        rd(ra(2, 6'h20), v); check("R7 status capture", v, 32'h0000_2402);
        rd(ra(2, 6'h24), v); check("R7 fault address", v, 32'h1234_5000);
        check("R10 irq with enable", 32'(irq), 1);
        fault(2, 4'b1000, 3'd5, 2'd1, 32'h0000_BBBB);
        rd(ra(2, 6'h20), v); check("R8 status kept", v, 32'h0000_2402);
        rd(ra(2, 6'h24), v); check("R8 address kept", v, 32'h1234_5000);
        wr(ra(2, 6'h24), 32'h5555_5555);
        rd(ra(2, 6'h24), v); check("R9 faddr write ignored", v, 32'h1234_5000);
        wr(ra(2, 6'h20), 32'hFFFF_FFFF);
        rd(ra(2, 6'h20), v); check("R9 status cleared", v, 0);
        rd(ra(2, 6'h24), v); check("R9 address cleared", v, 0);
        check("R10 irq drops", 32'(irq), 0);
        fault(2, 4'b1101, 3'd1, 2'd3, 32'h0000_0040);
        rd(ra(2, 6'h20), v); check("R7 multi-flag mapping", v, 32'h0000_3115);
        @(negedge clk);
        wr_en = 1'b1; addr = ra(2, 6'h20); wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        rd(ra(2, 6'h20), v); check("R9 zero write clears", v, 0);
        @(negedge clk);
        wr_en = 1'b1; addr = ra(2, 6'h20); wdata = 32'h0;
        flt_pulse[2] = 1'b1; flt_flags = 4'b0001; flt_code = 3'd1; flt_addr = 32'h99;
        @(negedge clk);
        wr_en = 1'b0; flt_pulse = '0;
        rd(ra(2, 6'h20), v); check("R9 write beats fault", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        fault(0, 4'b0001, 3'd0, 2'd0, 32'h0000_1000);
        rd(ra(0, 6'h20), v); check("R7 ctx0 fault", v, 32'h1);
        check("R10 no irq without enable", 32'(irq), 0);
        wr(ra(0, 6'h00), 32'h5);
        check("R10 irq after enable", 32'(irq), 1);
        wr(ra(0, 6'h20), 32'h0);
        check("R10 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_oob();
        logic [31:0] v;
        wr(ra(3, 6'h08), 32'h0000_0055);
        rd(ra(3, 6'h08), v); check("R11 ctx3 reads 0", v, 0);
        rd(ra(7, 6'h00), v); check("R11 ctx7 reads 0", v, 0);
        wr(ra(0, 6'h04), 32'hFFFF_FFFF);
        wr(ra(0, 6'h0C), 32'hFFFF_FFFF);
        rd(ra(0, 6'h04), v); check("R11 unmapped reads 0", v, 0);
        rd(ra(0, 6'h00), v); check("R11 ctrl untouched", v, 32'h5);
        rd(ra(0, 6'h08), v); check("R11 tctl untouched", v, 0);
        rd(ra(1, 6'h08), v); check("R11 ctx1 tctl untouched", v, 32'hA5A5_1234);
        check("R11 no flush raised", 32'(flush_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_flush();
        t_fault();
        t_irq();
        t_oob();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule